// File: doc/BRIEF.md
# DMA FIFO Byte-Lane Diagnostic Controller

This block wraps a 32-bit DMA FIFO and adds a small control port for test software. Through that port software can read or overwrite any single byte lane of the word at the head of the FIFO. It can also step a DMA address pointer up to the next 32-bit boundary and step a 24-bit byte counter down by the same amount. A mode bit chooses how deep the FIFO appears to be: 88 bytes or 536 bytes. The smaller depth lets older residual-count software work out how many bytes are left after a transfer stops.

Words enter and leave through valid/ready streams. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops when one more word would take the stored byte count past the apparent depth. A word offered while `in_ready` is low is dropped, and the sticky overflow flag is set. A word leaves on an edge where `out_valid` and `out_ready` are both high. `out_valid` is high whenever at least one word is stored, and the head word is held stable while it waits.

The control port has three registers, selected by `reg_addr`:
- Register 0 is the lane control register.
- Register 1 is the step and mode register.
- Register 2 is the test data byte.

The pointer and the counter are loaded from the DMA side through `dma_load`.

Top module: `dfd_top`

## Requirements
- R1: After reset, registers 0 and 1 read 0, the apparent depth is 88 bytes, the FIFO is empty (`out_valid`=0, `fifo_level`=0, `in_ready`=1), and `fifo_overflow` and `par_irq` are 0.
- R2: Words are delivered on `out_data` in the order they were accepted, each one once. A word is accepted on an edge with `in_valid`&&`in_ready`, and removed on an edge with `out_valid`&&`out_ready`. The head word holds steady while `out_ready` is low.
- R3: Register 1 bit 5 selects the apparent depth: 0 means 88 bytes (22 words) and 1 means 536 bytes (134 words). `in_ready` is low exactly when one more 4-byte word would exceed that depth.
- R4: `fifo_level` equals 4 × the stored word count, capped at the current apparent depth. The cap applies even after the depth is lowered while more is stored.
- R5: A word offered while `in_ready` is low is dropped, and `fifo_overflow` becomes 1. The flag stays 1 until reset.
- R6: Register 0 bits 2:0 are {enable, select[1:0]}. With enable=1, register 2 reads and writes lane `select` of the head word. Lane n is `out_data` bits 8n+7:8n.
- R7: With register 0 bit 2 clear, register 2 uses the lane given by `dma_addr[1:0]`.
- R8: A write to register 2 changes only the chosen byte of the head word. The other three bytes keep their values.
- R9: Writing register 1 with bit 7 set adds span = min(4 − `dma_addr[1:0]`, `dma_cnt`) to `dma_addr` once. Bit 7 always reads back 0.
- R10: Writing register 1 with bit 6 set subtracts the same span from `dma_cnt` once, so the count never goes below zero. Bit 6 always reads back 0.
- R11: When bits 7 and 6 are written together, both steps use the span computed from the values held before that write.
- R12: Register 0 bit 3 enables master parity reporting. `par_irq` in a cycle equals enable && `par_err` from the previous cycle, so with the bit clear a parity error never raises `par_irq`.
- R13: `dma_load` loads `dma_addr` and `dma_cnt` on the next edge, and it takes priority over a step written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| in_valid | input | 1 | Push word valid |
| in_ready | output | 1 | FIFO can take a word within apparent depth |
| in_data | input | 32 | Push word |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Consumer takes head word |
| out_data | output | 32 | Head word |
| fifo_level | output | 10 | Stored bytes, capped at apparent depth |
| fifo_overflow | output | 1 | Sticky dropped-push flag |
| dma_load | input | 1 | Load pointer and counter |
| dma_addr_in | input | 32 | Pointer load value |
| dma_cnt_in | input | 24 | Counter load value |
| dma_addr | output | 32 | DMA address pointer |
| dma_cnt | output | 24 | DMA byte counter |
| par_err | input | 1 | Master parity error detected |
| par_irq | output | 1 | Parity interrupt request |

## Verification
The embedded assertions check several properties on every cycle:
- The counter never rises on a count step.
- An address step with four or more bytes left always lands on a word boundary.
- A load overrides any step.
- The overflow flag never clears.
- A waiting head word never changes.
- A masked parity error never raises the interrupt.

The scenarios cover what no single-cycle property can show. They fill the FIFO to both depths with drops, check capped levels after the depth is lowered, and check word ordering over a full drain. They also sweep the diagnostic lane reads and single-byte writes over every lane in both lane modes. Finally, they check exact step arithmetic over every address alignment against small counts, for each strobe alone and for both together.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
  typedef enum logic [1:0] {
    REG_LANE  = 2'd0,
    REG_STEP  = 2'd1,
    REG_TDATA = 2'd2,
    REG_NONE  = 2'd3
  } dfd_reg_e;

  localparam int STEP_ADDR_BIT = 7;
  localparam int STEP_CNT_BIT  = 6;
  localparam int DEEP_BIT      = 5;
  localparam int MPE_BIT       = 3;
  localparam int LANE_EN_BIT   = 2;
endpackage

// File: rtl/dfd_step.sv
module dfd_step #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          do_addr,
  input  logic          do_cnt,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt
);
  logic [2:0] gap;
  logic [2:0] span;

  always_comb begin
    gap  = 3'd4 - {1'b0, addr[1:0]};
    span = (cnt < CW'(gap)) ? cnt[2:0] : gap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else if (load) begin
      addr <= load_addr;
      cnt  <= load_cnt;
    end else begin
      if (do_addr) addr <= addr + AW'(span);
      if (do_cnt)  cnt  <= cnt - CW'(span);
    end
  end

  // R10: a count step never raises (wraps) the counter
  a_r10_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cnt && !load) |=> (cnt <= $past(cnt)));
  // R9: with a full word of count left, an address step lands on a boundary
  a_r9_addr_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    (do_addr && !load && cnt >= CW'(4)) |=> (addr[1:0] == 2'b00));
  // R13: load overrides any step
  a_r13_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(load_addr) && cnt == $past(load_cnt)));
endmodule

// File: rtl/dfd_fifo.sv
module dfd_fifo #(
  parameter int DW          = 32,
  parameter int LW          = 8,
  parameter int SMALL_BYTES = 88,
  parameter int LARGE_BYTES = 536,
  localparam int LANES      = DW / LW,
  localparam int MAX_WORDS  = LARGE_BYTES / LANES,
  localparam int PW         = $clog2(MAX_WORDS),
  localparam int CNTW       = $clog2(MAX_WORDS + 1),
  localparam int LVW        = $clog2(LARGE_BYTES + 1),
  localparam int SW         = $clog2(LANES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           deep,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  input  logic [SW-1:0]  lane,
  input  logic           lane_we,
  input  logic [LW-1:0]  lane_wdata,
  output logic [LW-1:0]  lane_rdata,
  output logic [LVW-1:0] level,
  output logic           overflow
);
  logic [DW-1:0]   mem [MAX_WORDS];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic [LVW-1:0]  depth_bytes, stored_bytes;
  logic [LVW:0]    next_fill;
  logic            push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(MAX_WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    depth_bytes  = deep ? LVW'(LARGE_BYTES) : LVW'(SMALL_BYTES);
    stored_bytes = LVW'(count) * LVW'(LANES);
    next_fill    = {1'b0, stored_bytes} + (LVW+1)'(LANES);
    in_ready     = next_fill <= {1'b0, depth_bytes};
    out_valid    = count != '0;
    push         = in_valid && in_ready;
    pop          = out_valid && out_ready;
    level        = (stored_bytes > depth_bytes) ? depth_bytes : stored_bytes;
    out_data     = mem[rd_ptr];
    lane_rdata   = mem[rd_ptr][int'(lane)*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
    if (lane_we) mem[rd_ptr][int'(lane)*LW +: LW] <= lane_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (in_valid && !in_ready) overflow <= 1'b1;
    end
  end

  // R3: storage count never exceeds the large depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(MAX_WORDS));
  // R5: overflow is sticky
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R2: a waiting head word is held
  a_r2_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !lane_we) |=> $stable(out_data));
endmodule

// File: rtl/dfd_top.sv
module dfd_top #(
  parameter int AW          = 32,
  parameter int CW          = 24,
  parameter int SMALL_BYTES = 88,
  parameter int LARGE_BYTES = 536,
  localparam int DW         = 32,
  localparam int LW         = 8,
  localparam int LVW        = $clog2(LARGE_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic [LVW-1:0] fifo_level,
  output logic           fifo_overflow,
  input  logic           dma_load,
  input  logic [AW-1:0]  dma_addr_in,
  input  logic [CW-1:0]  dma_cnt_in,
  output logic [AW-1:0]  dma_addr,
  output logic [CW-1:0]  dma_cnt,
  input  logic           par_err,
  output logic           par_irq
);
  import dfd_pkg::*;

  logic       lane_en, mpe, deep;
  logic [1:0] lane_sel, lane;
  logic       wr_lane, wr_step, wr_tdata;
  logic       do_addr, do_cnt;
  logic [7:0] lane_rdata;

  always_comb begin
    wr_lane  = reg_we && (dfd_reg_e'(reg_addr) == REG_LANE);
    wr_step  = reg_we && (dfd_reg_e'(reg_addr) == REG_STEP);
    wr_tdata = reg_we && (dfd_reg_e'(reg_addr) == REG_TDATA);
    do_addr  = wr_step && reg_wdata[STEP_ADDR_BIT];
    do_cnt   = wr_step && reg_wdata[STEP_CNT_BIT];
    lane     = lane_en ? lane_sel : dma_addr[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_en  <= 1'b0;
      lane_sel <= '0;
      mpe      <= 1'b0;
      deep     <= 1'b0;
      par_irq  <= 1'b0;
    end else begin
      if (wr_lane) begin
        mpe      <= reg_wdata[MPE_BIT];
        lane_en  <= reg_wdata[LANE_EN_BIT];
        lane_sel <= reg_wdata[1:0];
      end
      if (wr_step) deep <= reg_wdata[DEEP_BIT];
      par_irq <= mpe && par_err;
    end
  end

  always_comb begin
    case (dfd_reg_e'(reg_addr))
      REG_LANE:  reg_rdata = {4'b0, mpe, lane_en, lane_sel};
      REG_STEP:  reg_rdata = {2'b0, deep, 5'b0};
      REG_TDATA: reg_rdata = lane_rdata;
      default:   reg_rdata = 8'h00;
    endcase
  end

  dfd_fifo #(
    .DW(DW), .LW(LW), .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .deep(deep),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .lane(lane), .lane_we(wr_tdata), .lane_wdata(reg_wdata),
    .lane_rdata(lane_rdata), .level(fifo_level), .overflow(fifo_overflow)
  );

  dfd_step #(.AW(AW), .CW(CW)) u_step (
    .clk(clk), .rst_n(rst_n), .load(dma_load),
    .load_addr(dma_addr_in), .load_cnt(dma_cnt_in),
    .do_addr(do_addr), .do_cnt(do_cnt),
    .addr(dma_addr), .cnt(dma_cnt)
  );

  // R12: masked parity errors never interrupt
  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !mpe |=> !par_irq);
endmodule

// File: tb/test_dfd_top.sv
module test_dfd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [9:0]  fifo_level;
  logic        fifo_overflow;
  logic        dma_load = 1'b0;
  logic [31:0] dma_addr_in = '0;
  logic [23:0] dma_cnt_in = '0;
  logic [31:0] dma_addr;
  logic [23:0] dma_cnt;
  logic        par_err = 1'b0;
  logic        par_irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dfd_top i_dfd_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_level(fifo_level), .fifo_overflow(fifo_overflow),
    .dma_load(dma_load), .dma_addr_in(dma_addr_in), .dma_cnt_in(dma_cnt_in),
    .dma_addr(dma_addr), .dma_cnt(dma_cnt), .par_err(par_err), .par_irq(par_irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, output bit acc);
    @(negedge clk); in_valid = 1'b1; in_data = d; #1 acc = in_ready;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d, output bit vld);
    @(negedge clk); #1 d = out_data; vld = out_valid; out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [23:0] c);
    @(negedge clk); dma_load = 1'b1; dma_addr_in = a; dma_cnt_in = c;
    @(negedge clk); dma_load = 1'b0;
  endtask

  function automatic logic [31:0] word_of(input int i);
    return 32'(i) * 32'h01030507 + 32'h10203040;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [31:0] d, w, e;
    bit          acc, vld;
    int          n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, r); chk(r == 8'h00, "R1 reg0", r, 0);
    rd(1, r); chk(r == 8'h00, "R1 reg1", r, 0);
    chk(out_valid == 0 && in_ready == 1, "R1 empty", {out_valid, in_ready}, 1);
    chk(fifo_level == 0, "R1 level", fifo_level, 0);
    chk(fifo_overflow == 0 && par_irq == 0, "R1 flags", {fifo_overflow, par_irq}, 0);

    // R3/R5 small depth fill with drop attempt
    n = 0;
    for (int i = 0; i < 23; i++) begin
      push(word_of(n), acc);
      if (acc) n++;
    end
    chk(n == 22, "R3 small depth words", n, 22);
    chk(fifo_level == 88, "R4 level small", fifo_level, 88);
    chk(in_ready == 0, "R3 not ready at small depth", in_ready, 0);
    chk(fifo_overflow == 1, "R5 overflow set", fifo_overflow, 1);

    // R3 large depth
    wr(1, 8'h20);
    rd(1, r); chk(r == 8'h20, "R3 deep readback", r, 8'h20);
    for (int i = 0; i < 113; i++) begin
      push(word_of(n), acc);
      if (acc) n++;
    end
    chk(n == 134, "R3 large depth words", n, 134);
    chk(fifo_level == 536, "R4 level large", fifo_level, 536);

    // R4 cap after lowering depth
    wr(1, 8'h00);
    chk(fifo_level == 88, "R4 capped after lowering", fifo_level, 88);

    // R2 drain in order
    for (int i = 0; i < 134; i++) begin
      pop(d, vld);
      chk(vld && d == word_of(i), "R2 order", d, word_of(i));
    end
    #1 chk(out_valid == 0 && fifo_level == 0, "R2 drained", fifo_level, 0);
    chk(fifo_overflow == 1, "R5 overflow sticky", fifo_overflow, 1);

    // R6/R8 selected lane read and single-byte write
    for (int l = 0; l < 4; l++) begin
      w = 32'h8899AABB ^ (32'(l) * 32'h11111111);
      push(w, acc);
      for (int k = 0; k < 4; k++) begin
        wr(0, 8'(4 | k));
        rd(2, r); chk(r == w[8*k +: 8], "R6 lane read", r, w[8*k +: 8]);
      end
      wr(0, 8'(4 | l));
      wr(2, 8'(8'hC0 | l));
      rd(2, r); chk(r == 8'(8'hC0 | l), "R6 lane write readback", r, 8'(8'hC0 | l));
      e = w; e[8*l +: 8] = 8'(8'hC0 | l);
      pop(d, vld);
      chk(d == e, "R8 only selected byte changed", d, e);
    end

    // R7 lane from address pointer
    wr(0, 8'h00);
    w = 32'hDEADBEEF;
    push(w, acc);
    for (int a = 0; a < 4; a++) begin
      load(32'h1000 | 32'(a), 24'd100);
      rd(2, r); chk(r == w[8*a +: 8], "R7 address lane read", r, w[8*a +: 8]);
    end
    load(32'h1002, 24'd100);
    wr(2, 8'h5A);
    e = w; e[23:16] = 8'h5A;
    pop(d, vld);
    chk(d == e, "R7 address lane write", d, e);

    // R9/R10/R11 step sweep
    for (int a = 0; a < 4; a++) begin
      for (int ci = 0; ci < 6; ci++) begin
        for (int m = 1; m < 4; m++) begin
          int c, sp;
          logic [31:0] ea;
          logic [23:0] ec;
          c  = (ci == 5) ? 7 : ci;
          sp = (c < 4 - a) ? c : 4 - a;
          load(32'h2000 + 32'(a), 24'(c));
          wr(1, {m[0], m[1], 6'b0});
          ea = 32'h2000 + 32'(a) + (m[0] ? 32'(sp) : 32'd0);
          ec = 24'(c) - (m[1] ? 24'(sp) : 24'd0);
          if (m == 3) begin
            chk(dma_addr == ea, "R11 both steps addr", dma_addr, ea);
            chk(dma_cnt == ec, "R11 both steps cnt", dma_cnt, ec);
          end else begin
            chk(dma_addr == ea, "R9 addr step", dma_addr, ea);
            chk(dma_cnt == ec, "R10 cnt step", dma_cnt, ec);
          end
        end
      end
    end
    rd(1, r); chk(r[7:6] == 2'b00, "R9 R10 strobes self clear", r, 0);

    // R13 load beats a same-cycle step
    @(negedge clk);
    dma_load = 1'b1; dma_addr_in = 32'h3001; dma_cnt_in = 24'd50;
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hC0;
    @(negedge clk);
    dma_load = 1'b0; reg_we = 1'b0;
    chk(dma_addr == 32'h3001 && dma_cnt == 24'd50, "R13 load priority", dma_addr, 32'h3001);

    // R12 parity masking
    wr(0, 8'h00);
    @(negedge clk); par_err = 1'b1;
    @(negedge clk); par_err = 1'b0;
    chk(par_irq == 0, "R12 masked", par_irq, 0);
    wr(0, 8'h08);
    @(negedge clk); par_err = 1'b1;
    @(negedge clk); par_err = 1'b0;
    chk(par_irq == 1, "R12 enabled irq", par_irq, 1);
    @(negedge clk);
    chk(par_irq == 0, "R12 irq follows error", par_irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule